// File: doc/BRIEF.md
# Coincidence-State Early/Late Phase Sampler

This block runs from a fast local clock (nominally 155.52 MHz) and keeps a modulo-1944 tick counter. The counter's wrap period, 12.5 us, is the common period of the local clock and a 10 MHz reference. Counter state 0 lines up exactly with a reference rising edge. At a few other states a local tick lands within a fraction of a tick of a reference edge. Because 125 × 1493 ≡ 1 (mod 1944), every residue is a whole multiple of 100000/1944 ≈ 51.44 ps. The nearest states are 451 (51.44 ps early), 1493 (51.44 ps late), 902 (102.88 ps early) and 1042 (102.88 ps late).

At each enabled tap state, the block samples an already-synchronized copy of the reference level. One clock later it reports a single bang-bang decision bit. The decision carries the index of the tap that produced it and that tap's signed offset constant in picoseconds. A loop filter outside the block averages these decisions to steer the local oscillator. Sampling at several near-coincidence states gives many more phase observations per 12.5 us than state 0 alone, and each observation carries a known bias. A per-tap enable mask selects the exact-alignment tap alone or any subset of the taps.

Top module: `coinc_phase_sampler`

## Requirements
- R1: The counter output starts at 0 after reset, increments by one on every clock, and returns to 0 on the clock after it shows 1943.
- R2: The wrap output is high for exactly the cycle in which the counter shows 0 after having shown 1943. It is low in all other cycles, including the first cycle after reset.
- R3: If the counter shows an enabled tap state in cycle n, the decision valid output is high in cycle n+1. It is low in every cycle that does not follow an enabled tap state.
- R4: In a valid cycle the decision bit equals the reference level that was present in cycle n. A 1 means late: the reference edge has already passed. A 0 means early.
- R5: In a valid cycle the tag output carries the tap index and the offset output carries that tap's signed constant in ps. The default taps, by index 0 to 4, are states 0, 451, 902, 1042 and 1493, with offsets 0, -51, -103, +103 and +51. Between decisions, the decision bit, tag and offset hold their last values.
- R6: Bit i of the enable mask gates tap i. A cleared bit yields no strobe for that tap. Mask 5'b00001 yields only the exact-alignment decision. Mask 0 yields none.
- R7: Consider a 10 MHz reference whose rising edges are displaced by o ps (positive means later) from exact alignment, high for the first 50 ns of each period. Each tap reports late exactly when o is at or below its threshold and early above it. The thresholds are 0 for tap 0, -52 for tap 1, -103 for tap 2, 102 for tap 3 and 51 for tap 4.
- R8: During reset the counter, wrap, valid, decision bit, tag and offset outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_sync_i | input | 1 | Reference level, already synchronized to clk |
| tap_en_i | input | NUM_TAPS (5) | Per-tap enable mask |
| late_o | output | 1 | Decision bit: 1 late, 0 early |
| dec_valid_o | output | 1 | One-cycle strobe marking a new decision |
| dec_tag_o | output | TAG_W (3) | Index of the tap that produced the decision |
| dec_skew_o | output | SKEW_W (16) | Signed offset constant of that tap, in ps |
| cnt_o | output | CW (11) | Current counter state |
| wrap_o | output | 1 | Pulse in the cycle the counter has wrapped to 0 |

## Verification
The bench builds the block with its default parameters: modulus 1944 and the five taps at 0, 451, 902, 1042 and 1493. With these values the model can form the reference level from exact integer residues of k × 12.5 us / 1944 against a 100 ns period. This puts each tap's threshold within reach at one-picosecond steps of reference displacement, on both sides of each threshold. The same default build lets the mask cases single out the exact-alignment tap, pick a subset, and switch every tap off, each across a full 1944-state period.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

   localparam int DEF_TAPS = 5;

   typedef int tap_int_t [DEF_TAPS];

   // near-coincidence counter states, index 0 is exact alignment
   localparam tap_int_t DEF_STATE = '{0, 451, 902, 1042, 1493};

   // signed position of each state against the nearest reference edge, ps
   localparam tap_int_t DEF_SKEW  = '{0, -51, -103, 103, 51};

   function automatic int idx_w(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/coinc_counter.sv
module coinc_counter #(
   parameter int MOD = 1944,
   parameter int CW  = $clog2(MOD)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] cnt_o,
   output logic          wrap_o
);

   localparam logic [CW-1:0] LAST = CW'(MOD - 1);

   logic [CW-1:0] cnt_q;
   logic          wrap_q;

   if (MOD < 2) begin : g_bad_mod
      $error("coinc_counter: MOD must be at least 2");
   end
   if ((1 << CW) < MOD) begin : g_bad_cw
      $error("coinc_counter: CW too narrow for MOD");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         wrap_q <= 1'b0;
      end else begin
         if (cnt_q == LAST) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
         wrap_q <= (cnt_q == LAST);
      end
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = wrap_q;

   assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

   assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |-> (cnt_q == '0));

endmodule

// File: rtl/coinc_tap_match.sv
module coinc_tap_match #(
   parameter int MOD      = 1944,
   parameter int CW       = $clog2(MOD),
   parameter int NUM_TAPS = coinc_pkg::DEF_TAPS,
   parameter int TAG_W    = coinc_pkg::idx_w(NUM_TAPS),
   parameter int SKEW_W   = 16,
   parameter int TAP_STATE [NUM_TAPS] = coinc_pkg::DEF_STATE,
   parameter int TAP_SKEW  [NUM_TAPS] = coinc_pkg::DEF_SKEW
) (
   input  logic [CW-1:0]       cnt_i,
   input  logic [NUM_TAPS-1:0] en_i,
   output logic                hit_o,
   output logic [TAG_W-1:0]    tag_o,
   output logic [SKEW_W-1:0]   skew_o
);

   logic [NUM_TAPS-1:0] eq;

   for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
      if (TAP_STATE[g] < 0 || TAP_STATE[g] >= MOD) begin : g_bad_state
         $error("coinc_tap_match: tap state out of counter range");
      end
      if (TAP_SKEW[g] >= (1 <<< (SKEW_W - 1)) ||
          TAP_SKEW[g] < -(1 <<< (SKEW_W - 1))) begin : g_bad_skew
         $error("coinc_tap_match: tap offset does not fit SKEW_W");
      end
      assign eq[g] = en_i[g] && (cnt_i == CW'(TAP_STATE[g]));
   end

   // lowest index wins when taps share a state
   always_comb begin
      hit_o  = 1'b0;
      tag_o  = '0;
      skew_o = '0;
      for (int i = NUM_TAPS - 1; i >= 0; i--) begin
         if (eq[i]) begin
            hit_o  = 1'b1;
            tag_o  = TAG_W'(i);
            skew_o = SKEW_W'(TAP_SKEW[i]);
         end
      end
   end

   always_comb begin
      if (hit_o) begin
         assert_hit_enabled_R6: assert (en_i[tag_o]);
      end
   end

endmodule

// File: rtl/coinc_decide.sv
module coinc_decide #(
   parameter int TAG_W  = 3,
   parameter int SKEW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_i,
   input  logic [TAG_W-1:0]  tag_i,
   input  logic [SKEW_W-1:0] skew_i,
   input  logic              ref_i,
   output logic              valid_o,
   output logic              late_o,
   output logic [TAG_W-1:0]  tag_o,
   output logic [SKEW_W-1:0] skew_o
);

   if (TAG_W < 1 || SKEW_W < 2) begin : g_bad_w
      $error("coinc_decide: widths too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         late_o  <= 1'b0;
         tag_o   <= '0;
         skew_o  <= '0;
      end else begin
         valid_o <= hit_i;
         if (hit_i) begin
            late_o <= ref_i;
            tag_o  <= tag_i;
            skew_o <= skew_i;
         end
      end
   end

   assert_valid_follows_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(hit_i));

   assert_late_is_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (late_o == $past(ref_i)));

   assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_i |=> ($stable(tag_o) && $stable(skew_o) && $stable(late_o)));

endmodule

// File: rtl/coinc_phase_sampler.sv
module coinc_phase_sampler #(
   parameter int MOD      = 1944,
   parameter int NUM_TAPS = coinc_pkg::DEF_TAPS,
   parameter int SKEW_W   = 16,
   parameter int TAP_STATE [NUM_TAPS] = coinc_pkg::DEF_STATE,
   parameter int TAP_SKEW  [NUM_TAPS] = coinc_pkg::DEF_SKEW,
   localparam int CW    = $clog2(MOD),
   localparam int TAG_W = coinc_pkg::idx_w(NUM_TAPS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ref_sync_i,
   input  logic [NUM_TAPS-1:0]      tap_en_i,
   output logic                     late_o,
   output logic                     dec_valid_o,
   output logic [TAG_W-1:0]         dec_tag_o,
   output logic signed [SKEW_W-1:0] dec_skew_o,
   output logic [CW-1:0]            cnt_o,
   output logic                     wrap_o
);

   if (NUM_TAPS < 1) begin : g_bad_taps
      $error("coinc_phase_sampler: NUM_TAPS must be at least 1");
   end
   if (SKEW_W > 32) begin : g_bad_skew_w
      $error("coinc_phase_sampler: SKEW_W above 32");
   end

   logic [CW-1:0]     cnt;
   logic              hit;
   logic [TAG_W-1:0]  hit_tag;
   logic [SKEW_W-1:0] hit_skew;
   logic [SKEW_W-1:0] skew_q;

   coinc_counter #(
      .MOD (MOD),
      .CW  (CW)
   ) u_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_o  (cnt),
      .wrap_o (wrap_o)
   );

   coinc_tap_match #(
      .MOD       (MOD),
      .CW        (CW),
      .NUM_TAPS  (NUM_TAPS),
      .TAG_W     (TAG_W),
      .SKEW_W    (SKEW_W),
      .TAP_STATE (TAP_STATE),
      .TAP_SKEW  (TAP_SKEW)
   ) u_match (
      .cnt_i  (cnt),
      .en_i   (tap_en_i),
      .hit_o  (hit),
      .tag_o  (hit_tag),
      .skew_o (hit_skew)
   );

   coinc_decide #(
      .TAG_W  (TAG_W),
      .SKEW_W (SKEW_W)
   ) u_decide (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit),
      .tag_i   (hit_tag),
      .skew_i  (hit_skew),
      .ref_i   (ref_sync_i),
      .valid_o (dec_valid_o),
      .late_o  (late_o),
      .tag_o   (dec_tag_o),
      .skew_o  (skew_q)
   );

   assign cnt_o      = cnt;
   assign dec_skew_o = $signed(skew_q);

   assert_wrap_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |-> ($past(cnt) == CW'(MOD - 1)));

   assert_tag_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid_o |-> (int'(dec_tag_o) < NUM_TAPS));

   assert_valid_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid_o |-> ($past(tap_en_i) != '0));

endmodule

// File: tb/coinc_phase_sampler_bench.sv
module coinc_phase_sampler_bench;

   localparam int MOD = 1944;
   localparam int NT  = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_sync = 1'b0;
   logic [NT-1:0] tap_en = '1;
   logic        late, dec_valid, wrap;
   logic [2:0]  dec_tag;
   logic signed [15:0] dec_skew;
   logic [10:0] cnt;

   always #5 clk = ~clk;

   coinc_phase_sampler u_coinc_phase_sampler (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_sync_i  (ref_sync),
      .tap_en_i    (tap_en),
      .late_o      (late),
      .dec_valid_o (dec_valid),
      .dec_tag_o   (dec_tag),
      .dec_skew_o  (dec_skew),
      .cnt_o       (cnt),
      .wrap_o      (wrap)
   );

   int total = 0;
   int bad   = 0;

   int st  [NT] = '{0, 451, 902, 1042, 1493};
   int sk  [NT] = '{0, -51, -103, 103, 51};
   int thr [NT] = '{0, -52, -103, 102, 51};

   int m_cnt = 0;
   bit exp_v = 0, exp_late = 0, exp_wrap = 0;
   int exp_tag = 0, exp_skew = 0;
   int offs = 0;
   bit got_v [NT];
   bit got_late [NT];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // reference level seen by local tick k, units of 1/1944 ps
   function automatic bit ref_level(input int k, input int o);
      longint p;
      p = (longint'(k) * 64'sd12500000 - longint'(o) * 64'sd1944) % 64'sd194400000;
      if (p < 0) p += 64'sd194400000;
      return p < 64'sd97200000;
   endfunction

   task automatic compare_all();
      chk(int'(cnt) == m_cnt, "R1", "counter", cnt, m_cnt);
      chk(wrap == exp_wrap, "R2", "wrap", wrap, exp_wrap);
      chk(dec_valid == exp_v, "R3", "valid", dec_valid, exp_v);
      chk(late == exp_late, "R4", "decision", late, exp_late);
      chk(int'(dec_tag) == exp_tag, "R5", "tag", dec_tag, exp_tag);
      chk(int'(dec_skew) == exp_skew, "R5", "offset", dec_skew, exp_skew);
      if (dec_valid) begin
         got_v[dec_tag]    = 1'b1;
         got_late[dec_tag] = late;
      end
   endtask

   task automatic drive_next();
      bit lvl;
      bit hit;
      lvl = ref_level(m_cnt, offs);
      ref_sync = lvl;
      hit = 1'b0;
      for (int i = NT - 1; i >= 0; i--) begin
         if (tap_en[i] && st[i] == m_cnt) begin
            hit = 1'b1;
            exp_tag = i;
            exp_skew = sk[i];
         end
      end
      exp_v = hit;
      if (hit) exp_late = lvl;
      exp_wrap = (m_cnt == MOD - 1);
      m_cnt = (m_cnt + 1) % MOD;
   endtask

   task automatic tick();
      @(negedge clk);
      compare_all();
      drive_next();
   endtask

   task automatic run_case(input int o, input logic [NT-1:0] mask);
      offs = o;
      tap_en = mask;
      repeat (2) tick();
      for (int i = 0; i < NT; i++) begin
         got_v[i] = 1'b0;
         got_late[i] = 1'b0;
      end
      repeat (MOD) tick();
      for (int i = 0; i < NT; i++) begin
         chk(got_v[i] == mask[i], "R6", $sformatf("strobe tap%0d off=%0d", i, o),
             got_v[i], mask[i]);
         if (mask[i] && got_v[i]) begin
            chk(got_late[i] == (o <= thr[i]), "R7",
                $sformatf("flip tap%0d off=%0d", i, o), got_late[i], (o <= thr[i]));
         end
      end
   endtask

   initial begin
      #1_500_000;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int offs_list [14] = '{1, 0, -51, -52, -53, -102, -103, -104,
                             50, 51, 52, 101, 102, 103};
      repeat (3) begin
         @(negedge clk);
         chk(cnt == 0 && wrap == 0 && dec_valid == 0, "R8", "reset ctl", {cnt, wrap, dec_valid}, 0);
         chk(late == 0 && dec_tag == 0 && dec_skew == 0, "R8", "reset data",
             {late, dec_tag, dec_skew}, 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      m_cnt = 0;
      drive_next();
      foreach (offs_list[j]) run_case(offs_list[j], 5'b11111);
      run_case(0, 5'b00001);
      run_case(1, 5'b00001);
      run_case(-103, 5'b10100);
      run_case(0, 5'b00000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule